// File: doc/BRIEF.md
# Masked-Write General-Purpose I/O Port

This block is a general-purpose I/O port with sixteen pins by default. It has three registers on a simple word-wide register interface: an output-value register, a pin-state register and a direction register. A write to the output-value or direction register carries its own per-bit change mask in the upper half of the data word and the new bit values in the lower half. Software can therefore set or clear any group of pins in a single write, with no read-modify-write sequence and no race against other code that shares the port.

A pin whose direction bit is 1 is a push-pull output that drives the matching output-value bit. A pin whose direction bit is 0 is released to high impedance. The block drives separate data and enable lines toward the pad ring, so the pad cell itself sits outside it. Every pin, whether it is an input or an output, is sampled back from the pad through a two-flop synchroniser. The pin-state register shows the result.

Top module: `mgpio_port`

## Requirements
- R1: After reset, the output-value and direction registers are all zeros. All `pin_oe` bits are therefore 0 (every pin is an input) and `pin_out` is 0.
- R2: On a write to offset 0x0 (output value) or offset 0x8 (direction), each register bit i takes data bit i when data bit 16+i is 1. Every bit whose mask bit is 0 keeps its state.
- R3: A write whose mask half (bits 31:16) is zero leaves the addressed register unchanged, for example 0x0000FFFF.
- R4: `pin_oe` bit i equals direction bit i, and `pin_out` carries the output-value register. A direction bit of 1 therefore drives its pin with the matching output-value bit.
- R5: A read of offset 0x4 returns the synchronised state of all pins, inputs and driven outputs alike, in bits 15:0. Bits 31:16 read 0.
- R6: A change on `pin_in` reaches the 0x4 read data on the second rising clock edge after it, and not on the first.
- R7: A read of offset 0x0 or 0x8 returns that register's 16 bits in bits 15:0, with bits 31:16 zero.
- R8: A write to offset 0x4 or to any unmapped offset (for example 0xC) changes neither the output-value nor the direction register. A read of an unmapped offset returns 0.
- R9: A write to one of the two writable registers leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data: change mask in 31:16, new values in 15:0 |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pin_in | input | 16 | Pin levels seen from the pads |
| pin_out | output | 16 | Output data toward the pads |
| pin_oe | output | 16 | Per-pin output enable (1 = drive) |

## Verification
The bench builds the block with its default parameters: 16 pins, a 32-bit data word and two synchroniser stages. With these values the mask sits exactly in bits 31:16, and the two-edge synchroniser delay can be observed cycle by cycle. The bench models the pad as a resistive bus, in which an enabled pin reflects `pin_out` and a released pin reflects an external level. This brings the read-back of driven outputs and of inputs within reach in the same read. The write patterns cover a partial mask, a full mask, a zero mask, the read-only offset, an unmapped offset, and single-bit set and clear of the direction register.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;

   // Byte offsets of the three registers
   localparam int unsigned OFS_VALUE = 'h0;
   localparam int unsigned OFS_PINS  = 'h4;
   localparam int unsigned OFS_DIR   = 'h8;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_VALUE = 2'd1,
      SEL_PINS  = 2'd2,
      SEL_DIR   = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/mgpio_masked_reg.sv
// Register updated by a masked write: upper half of the word is a change mask.
module mgpio_masked_reg #(
   parameter int unsigned          W       = 16,
   parameter int unsigned          DATA_W  = 32,
   parameter logic [W-1:0]         RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [W-1:0]      q
);

   localparam int unsigned MASK_LSB = DATA_W / 2;

   if (W > MASK_LSB) begin : g_bad_width
      $error("mgpio_masked_reg: W must not exceed DATA_W/2");
   end

   logic [W-1:0] wmask;
   logic [W-1:0] wval;
   logic [W-1:0] q_next;

   assign wmask = wdata[MASK_LSB +: W];
   assign wval  = wdata[W-1:0];

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign q_next[i] = wmask[i] ? wval[i] : q[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= RST_VAL;
      else if (wr_en) q <= q_next;
   end

   // R1: reset loads the reset value
   a_r1_reset_value: assert property (@(posedge clk) !rst_n |=> (q == RST_VAL));

   // R2: masked bits take the written value
   a_r2_masked_bits_take: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((q & $past(wmask)) == ($past(wval) & $past(wmask))));

   // R2: unmasked bits hold
   a_r2_unmasked_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((q & ~$past(wmask)) == ($past(q) & ~$past(wmask))));

   // R3: zero mask leaves register unchanged
   a_r3_zero_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wmask == '0)) |=> $stable(q));

   // R8/R9: no write strobe, no change
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(q));

endmodule

// File: rtl/mgpio_sync.sv
// Multi-stage synchroniser for asynchronous pin levels.
module mgpio_sync #(
   parameter int unsigned W      = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
      $error("mgpio_sync: STAGES must lie in 2..4");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];

   // R6: each stage is one edge behind the one before it
   for (genvar k = 0; k < STAGES; k++) begin : g_stage_chk
      if (k == 0) begin : g_first
         a_r6_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (chain[0] == $past(din)));
      end else begin : g_next
         a_r6_stage_step: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (chain[k] == $past(chain[k-1])));
      end
   end

endmodule

// File: rtl/mgpio_rdmux.sv
// Read-data selection with zero extension of every 16-bit source.
module mgpio_rdmux
   import mgpio_pkg::*;
#(
   parameter int unsigned W      = 16,
   parameter int unsigned DATA_W = 32
) (
   input  reg_sel_e          sel,
   input  logic [W-1:0]      value_q,
   input  logic [W-1:0]      dir_q,
   input  logic [W-1:0]      pins_q,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned PAD_W = DATA_W - W;

   logic [W-1:0] low;

   always_comb begin
      unique case (sel)
         SEL_VALUE: low = value_q;
         SEL_PINS:  low = pins_q;
         SEL_DIR:   low = dir_q;
         default:   low = '0;
      endcase
   end

   assign rdata = {{PAD_W{1'b0}}, low};

endmodule

// File: rtl/mgpio_port.sv
// GPIO port with masked-write output-value and direction registers.
module mgpio_port
   import mgpio_pkg::*;
#(
   parameter int unsigned PIN_W       = 16,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [PIN_W-1:0]  pin_in,
   output logic [PIN_W-1:0]  pin_out,
   output logic [PIN_W-1:0]  pin_oe
);

   if (DATA_W < 2 * PIN_W) begin : g_bad_data_w
      $error("mgpio_port: DATA_W must be at least twice PIN_W");
   end
   if ((1 << ADDR_W) <= OFS_DIR) begin : g_bad_addr_w
      $error("mgpio_port: ADDR_W too narrow for the register offsets");
   end

   reg_sel_e          sel;
   logic              wr_value;
   logic              wr_dir;
   logic [PIN_W-1:0]  value_q;
   logic [PIN_W-1:0]  dir_q;
   logic [PIN_W-1:0]  pins_q;

   // Full-address decode: aliases of the three offsets stay unmapped
   always_comb begin
      if (reg_addr == ADDR_W'(OFS_VALUE))     sel = SEL_VALUE;
      else if (reg_addr == ADDR_W'(OFS_PINS)) sel = SEL_PINS;
      else if (reg_addr == ADDR_W'(OFS_DIR))  sel = SEL_DIR;
      else                                    sel = SEL_NONE;
   end

   assign wr_value = reg_wr && (sel == SEL_VALUE);
   assign wr_dir   = reg_wr && (sel == SEL_DIR);

   mgpio_masked_reg #(
      .W       (PIN_W),
      .DATA_W  (DATA_W),
      .RST_VAL ('0)
   ) u_value_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_value),
      .wdata (reg_wdata),
      .q     (value_q)
   );

   mgpio_masked_reg #(
      .W       (PIN_W),
      .DATA_W  (DATA_W),
      .RST_VAL ('0)
   ) u_dir_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_dir),
      .wdata (reg_wdata),
      .q     (dir_q)
   );

   mgpio_sync #(
      .W      (PIN_W),
      .STAGES (SYNC_STAGES)
   ) u_pin_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pin_in),
      .dout  (pins_q)
   );

   mgpio_rdmux #(
      .W      (PIN_W),
      .DATA_W (DATA_W)
   ) u_rdmux (
      .sel     (sel),
      .value_q (value_q),
      .dir_q   (dir_q),
      .pins_q  (pins_q),
      .rdata   (reg_rdata)
   );

   assign pin_out = value_q;
   assign pin_oe  = dir_q;

   // R8: writes to the read-only offset touch neither register
   a_r8_pins_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && (sel == SEL_PINS)) |=> ($stable(value_q) && $stable(dir_q)));

   // R9: a direction write leaves the output value alone
   a_r9_dir_write_keeps_value: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> $stable(value_q));

   // R9: an output-value write leaves the direction alone
   a_r9_value_write_keeps_dir: assert property (@(posedge clk) disable iff (!rst_n)
      wr_value |=> $stable(dir_q));

   // R5/R7: upper half of read data is always zero
   a_r7_read_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[DATA_W-1:PIN_W] == '0));

endmodule

// File: tb/mgpio_port_tb.sv
module mgpio_port_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [15:0] pin_in;
   logic [15:0] pin_out;
   logic [15:0] pin_oe;
   logic [15:0] ext_lvl = '0;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   // Pad model: enabled pins reflect the driven value, others the outside level
   assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_lvl);

   mgpio_port u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(4'h0, d); check("R1 value after reset", d, 32'h0);
      rd(4'h8, d); check("R1 direction after reset", d, 32'h0);
      check("R1 pin_oe after reset", {16'h0, pin_oe}, 32'h0);
      check("R1 pin_out after reset", {16'h0, pin_out}, 32'h0);
   endtask

   task automatic t_masked_write();
      logic [31:0] d;
      wr(4'h8, 32'h0001_0001);
      rd(4'h8, d); check("R2 dir bit0 set", d, 32'h0000_0001);
      check("R4 oe follows dir", {16'h0, pin_oe}, 32'h0000_0001);
      wr(4'h8, 32'h0001_0000);
      rd(4'h8, d); check("R2 dir bit0 clear", d, 32'h0);
      wr(4'h0, 32'h4200_4200);
      rd(4'h0, d); check("R2 value set two bits", d, 32'h0000_4200);
      wr(4'h0, 32'h4200_0000);
      rd(4'h0, d); check("R2 value clear two bits", d, 32'h0);
      wr(4'h0, 32'hFFFF_A5A5);
      rd(4'h0, d); check("R2 value full mask", d, 32'h0000_A5A5);
      wr(4'h0, 32'h00F0_0000);
      rd(4'h0, d); check("R2 value partial clear", d, 32'h0000_A505);
      check("R4 pin_out carries value", {16'h0, pin_out}, 32'h0000_A505);
   endtask

   task automatic t_zero_mask();
      logic [31:0] d;
      wr(4'h0, 32'h0000_FFFF);
      rd(4'h0, d); check("R3 zero mask value", d, 32'h0000_A505);
      wr(4'h8, 32'h0000_0001);
      rd(4'h8, d); check("R3 zero mask direction", d, 32'h0);
   endtask

   task automatic t_direction_readback();
      logic [31:0] d;
      ext_lvl = 16'hF0F0;
      wr(4'h8, 32'hFFFF_00FF);
      check("R4 oe low byte", {16'h0, pin_oe}, 32'h0000_00FF);
      settle();
      rd(4'h4, d);
      check("R5 pins mixed in/out", d, {16'h0, (16'hA505 & 16'h00FF) | (16'hF0F0 & 16'hFF00)});
      wr(4'h8, 32'hFFFF_0000);
      settle();
      rd(4'h4, d); check("R5 pins all inputs", d, 32'h0000_F0F0);
   endtask

   task automatic t_sync_latency();
      rd(4'h4, reg_wdata);
      @(negedge clk);
      ext_lvl = 16'h1234;
      @(negedge clk); #1;
      check("R6 pins after one edge", reg_rdata, 32'h0000_F0F0);
      @(negedge clk); #1;
      check("R6 pins after two edges", reg_rdata, 32'h0000_1234);
   endtask

   task automatic t_upper_zero();
      logic [31:0] d;
      wr(4'h0, 32'hFFFF_FFFF);
      rd(4'h0, d); check("R7 value upper half zero", d, 32'h0000_FFFF);
      wr(4'h8, 32'hFFFF_FFFF);
      rd(4'h8, d); check("R7 direction upper half zero", d, 32'h0000_FFFF);
      settle();
      rd(4'h4, d); check("R5 pins upper half zero", d, 32'h0000_FFFF);
   endtask

   task automatic t_ignored();
      logic [31:0] d;
      wr(4'h0, 32'hFFFF_3C3C);
      wr(4'h8, 32'hFFFF_0F0F);
      wr(4'h4, 32'hFFFF_0000);
      rd(4'h0, d); check("R8 pins write keeps value", d, 32'h0000_3C3C);
      rd(4'h8, d); check("R8 pins write keeps dir", d, 32'h0000_0F0F);
      wr(4'hC, 32'hFFFF_0000);
      rd(4'h0, d); check("R8 unmapped write keeps value", d, 32'h0000_3C3C);
      rd(4'h8, d); check("R8 unmapped write keeps dir", d, 32'h0000_0F0F);
      rd(4'hC, d); check("R8 unmapped read zero", d, 32'h0);
   endtask

   task automatic t_independent();
      logic [31:0] d;
      wr(4'h8, 32'hFFFF_8001);
      rd(4'h0, d); check("R9 dir write keeps value", d, 32'h0000_3C3C);
      wr(4'h0, 32'hFFFF_1111);
      rd(4'h8, d); check("R9 value write keeps dir", d, 32'h0000_8001);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_reset();
      t_masked_write();
      t_zero_mask();
      t_direction_readback();
      t_sync_latency();
      t_upper_zero();
      t_ignored();
      t_independent();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule